// File: doc/BRIEF.md
# Event Interrupt Pending Controller

This block collects single-cycle event pulses from seventeen audio-subsystem sources and from sixty-four per-channel loop events. Each pulse is latched into a pending bit that stays set until software clears it. Enable registers gate the pending bits, and the gated result drives one registered interrupt line toward the host.

Software reaches the block through a plain register port: address, write data, write strobe and a combinational read-data bus. Six registers are mapped. The global pending register also carries a summary of the loop events. It shows whether any enabled loop channel is pending and which one has the highest number. Software can write that channel number back to clear just that channel. A force bit in the global enable register holds the interrupt line high whatever is pending.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every pending and enable register reads zero, any unmapped address (6 or 7) reads zero, and `irq` is low.
- R2: A pulse on `src_evt[k]` sets bit 8+k of the global pending register (address 0). The bit stays set until it is cleared. Source order k=0..16: rate-lock change, DSP, bus error, volume up, volume down, mute, mic full, mic half, ADC full, ADC half, effects full, effects half, S/PDIF A status, S/PDIF B status, interval timer, MIDI transmit empty, MIDI receive.
- R3: Writing address 0 clears each source bit (bits 24:8) written as 1 and leaves each bit written as 0 unchanged.
- R4: The global enable register (address 1) holds per-source enables in bits 13:0: bits 0-5 for sources 0-5, bit 6 for both mic events, bit 7 for both ADC events, bit 8 for both effects events, and bits 9-13 for sources 12-16. Bits 30:14 read as zero.
- R5: A pulse on `loop_evt[c]` sets bit c of the low loop pending register (address 2) for c<32, and bit c-32 of the high one (address 3) otherwise. Writing 1s to either register clears those bits. The loop enables are at addresses 4 (low) and 5 (high).
- R6: Bit 6 of address 0 reads 1 while any loop channel is both pending and enabled. Bits 5:0 then read the highest such channel number, and read 0 otherwise.
- R7: A write to address 0 with bit 6 set clears only the loop channel named by wdata[5:0]. With bit 6 clear, the channel field has no effect.
- R8: `irq` rises one cycle after any enabled source or enabled loop bit becomes pending, and falls one cycle after none remains.
- R9: Bit 31 of the global enable register forces `irq` high, one cycle after it is written, for as long as it stays set.
- R10: An event and a clear of the same bit in the same cycle leave the bit pending.
- R11: A pending bit whose enable is zero stays readable but does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| src_evt | input | 17 | Single-cycle source event pulses, one per source |
| loop_evt | input | 64 | Single-cycle loop event pulses, one per channel |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event and register inputs carry known values from the first clock edge. They also assume that a write strobe lasts exactly one cycle per access, so that each pending bit sees one clear per write. The bench drives every input to zero before reset is released and changes inputs only on falling edges. It raises each strobe and pulse for a single cycle. It creates the event-against-clear collision on purpose, inside that same single-cycle discipline.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int NUM_SRC   = 17;
  localparam int NUM_GEN   = 14;
  localparam int SRC_LSB   = 8;
  localparam int SUM_BIT   = 6;
  localparam int FORCE_BIT = 31;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_GPEND = 3'd0;
  localparam logic [ADDR_W-1:0] A_GEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LPEND = 3'd2;
  localparam logic [ADDR_W-1:0] A_LEN   = 3'd4;

  // Which enable bit gates source k: capture-buffer pairs share one enable.
  function automatic int src_en_idx(input int k);
    if (k < 6)       return k;
    else if (k < 12) return 6 + (k - 6) / 2;
    else             return k - 3;
  endfunction

endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         upd;

  // Next state: clear first, then set, so a same-cycle event survives.
  always_comb begin
    upd = (|evt) || (|clr);
    q_d = (q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end

  // R2 / R5: an event always leaves its bit set (also covers R10).
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((q & $past(evt)) == $past(evt)));

  // R3: a clear with no event empties the bit.
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~evt)) |=> ((q & $past(clr & ~evt)) == '0));

  // R2: no bit appears without an event.
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(evt)) == '0));

  // R2: a pending bit with no clear is kept.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(q) & ~$past(clr) & ~q) == '0));

endmodule

// File: rtl/evt_hi_find.sv
module evt_hi_find #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Upward scan: the last hit seen is the highest set bit.
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int LOOP_CH = 64,
  parameter int LANE_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_evt,
  input  logic [LOOP_CH-1:0]  loop_evt,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic                wr_en,
  output logic [31:0]         rdata,
  output logic                irq
);

  localparam int CH_W   = $clog2(LOOP_CH);
  localparam int N_LANE = LOOP_CH / LANE_W;

  logic [NUM_SRC-1:0] gpend;
  logic [NUM_SRC-1:0] gclr;
  logic [NUM_SRC-1:0] gen_exp;
  logic [NUM_GEN-1:0] gen_q;
  logic               force_q;
  logic [LOOP_CH-1:0] lpend;
  logic [LOOP_CH-1:0] lclr;
  logic [LOOP_CH-1:0] len_flat;
  logic [LOOP_CH-1:0] lp_en;
  logic               sum_any;
  logic [CH_W-1:0]    sum_idx;
  logic               irq_d;
  logic               wr_gp;
  logic               wr_gen;

  assign wr_gp  = wr_en && (addr == A_GPEND);
  assign wr_gen = wr_en && (addr == A_GEN);

  // ---------------- global source pending ----------------
  always_comb begin
    gclr = '0;
    if (wr_gp) gclr = wdata[SRC_LSB +: NUM_SRC];
  end

  evt_pend_bank #(.W(NUM_SRC)) u_gbank (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (src_evt),
    .clr  (gclr),
    .q    (gpend)
  );

  // ---------------- global enable ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= '0;
      force_q <= 1'b0;
    end else if (wr_gen) begin
      gen_q   <= wdata[NUM_GEN-1:0];
      force_q <= wdata[FORCE_BIT];
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src_en
    assign gen_exp[k] = gen_q[src_en_idx(k)];
  end

  // ---------------- loop pending clear decode ----------------
  always_comb begin
    lclr = '0;
    if (wr_gp && wdata[SUM_BIT]) lclr[wdata[CH_W-1:0]] = 1'b1;
    for (int ln = 0; ln < N_LANE; ln++) begin
      if (wr_en && (addr == ADDR_W'(int'(A_LPEND) + ln)))
        lclr[ln*LANE_W +: LANE_W] = lclr[ln*LANE_W +: LANE_W] | wdata[LANE_W-1:0];
    end
  end

  // ---------------- loop lanes: pending bank + enable ----------------
  for (genvar ln = 0; ln < N_LANE; ln++) begin : g_lane
    logic [LANE_W-1:0] len_q;
    logic              len_we;

    assign len_we = wr_en && (addr == ADDR_W'(int'(A_LEN) + ln));

    evt_pend_bank #(.W(LANE_W)) u_lbank (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (loop_evt[ln*LANE_W +: LANE_W]),
      .clr  (lclr[ln*LANE_W +: LANE_W]),
      .q    (lpend[ln*LANE_W +: LANE_W])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (len_we) len_q <= wdata[LANE_W-1:0];
    end

    assign len_flat[ln*LANE_W +: LANE_W] = len_q;
  end

  assign lp_en = lpend & len_flat;

  evt_hi_find #(.W(LOOP_CH), .IW(CH_W)) u_find (
    .vec(lp_en),
    .any(sum_any),
    .idx(sum_idx)
  );

  // ---------------- interrupt output ----------------
  always_comb irq_d = force_q || (|(gpend & gen_exp)) || sum_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    case (addr)
      A_GPEND: rdata = {7'b0, gpend, 1'b0, sum_any, sum_idx};
      A_GEN:   rdata = {force_q, 17'b0, gen_q};
      default: rdata = '0;
    endcase
    for (int ln = 0; ln < N_LANE; ln++) begin
      if (addr == ADDR_W'(int'(A_LPEND) + ln)) rdata = lpend[ln*LANE_W +: LANE_W];
      if (addr == ADDR_W'(int'(A_LEN) + ln))   rdata = len_flat[ln*LANE_W +: LANE_W];
    end
  end

  // ---------------- assertions ----------------
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gpend & gen_exp)) |=> irq);

  p_irq_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_any |=> irq);

  p_force_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> irq);

  p_sum_highest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_any |-> ((lp_en >> sum_idx) == LOOP_CH'(1)));

  p_sel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gp && wdata[SUM_BIT] && (loop_evt == '0))
      |=> (((lpend >> $past(wdata[CH_W-1:0])) & LOOP_CH'(1)) == '0));

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] src_evt;
  logic [63:0] loop_evt;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        wr_en;
  logic [31:0] rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .loop_evt(loop_evt),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_src(input logic [16:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic pulse_loop(input logic [63:0] m);
    loop_evt = m;
    @(negedge clk);
    loop_evt = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) chk_reg("R1 reset read", 3'(a), 32'h0);
    chk("R1 reset irq", irq, 1'b0);
  endtask

  task automatic t_src_hold;
    pulse_src(17'h1 << 3);
    chk_reg("R2 volume-up bit 11", 3'd0, 32'h0000_0800);
    repeat (3) @(negedge clk);
    chk_reg("R2 bit held", 3'd0, 32'h0000_0800);
    chk("R11 disabled no irq", irq, 1'b0);
    wr(3'd0, 32'h0000_0800);
    chk_reg("R3 single clear", 3'd0, 32'h0);
  endtask

  task automatic t_w1c;
    pulse_src(17'h7);
    chk_reg("R2 three sources", 3'd0, 32'h0000_0700);
    wr(3'd0, 32'h0000_0200);
    chk_reg("R3 clear one of three", 3'd0, 32'h0000_0500);
    wr(3'd0, 32'h0);
    chk_reg("R3 zero write no effect", 3'd0, 32'h0000_0500);
    wr(3'd0, 32'h01FF_FF00);
    chk_reg("R3 clear all", 3'd0, 32'h0);
  endtask

  task automatic t_shared;
    wr(3'd1, 32'h0000_0040);
    pulse_src(17'h1 << 7);
    chk("R8 latency irq still low", irq, 1'b0);
    @(negedge clk);
    chk("R4 mic half raises irq", irq, 1'b1);
    wr(3'd0, 32'h0000_8000);
    @(negedge clk);
    chk("R8 irq falls", irq, 1'b0);
    pulse_src(17'h1 << 6);
    @(negedge clk);
    chk("R4 mic full raises irq", irq, 1'b1);
    wr(3'd0, 32'h0000_4000);
    pulse_src(17'h1 << 8);
    @(negedge clk);
    chk("R11 ADC full disabled", irq, 1'b0);
    chk_reg("R11 ADC full visible", 3'd0, 32'h0001_0000);
    wr(3'd0, 32'h01FF_FF00);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_loop;
    pulse_loop((64'h1 << 3) | (64'h1 << 35));
    chk_reg("R5 low loop", 3'd2, 32'h0000_0008);
    chk_reg("R5 high loop", 3'd3, 32'h0000_0008);
    chk_reg("R6 disabled summary", 3'd0, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    chk_reg("R5 enable readback", 3'd5, 32'hFFFF_FFFF);
    chk_reg("R6 summary ch35", 3'd0, 32'h0000_0063);
    @(negedge clk);
    chk("R8 loop irq", irq, 1'b1);
    wr(3'd3, 32'h0000_0008);
    chk_reg("R5 high cleared", 3'd3, 32'h0);
    chk_reg("R6 summary ch3", 3'd0, 32'h0000_0043);
  endtask

  task automatic t_sel_clear;
    pulse_loop((64'h1 << 5) | (64'h1 << 40) | (64'h1 << 63));
    chk_reg("R6 summary ch63", 3'd0, 32'h0000_007F);
    wr(3'd0, 32'h0000_0040 | 32'd40);
    chk_reg("R7 only ch40 cleared", 3'd3, 32'h8000_0000);
    chk_reg("R7 summary unchanged", 3'd0, 32'h0000_007F);
    wr(3'd0, 32'h0000_0040 | 32'd63);
    chk_reg("R7 summary ch5", 3'd0, 32'h0000_0045);
    wr(3'd0, 32'd5);
    chk_reg("R7 no summary bit no clear", 3'd2, 32'h0000_0028);
    wr(3'd4, ~(32'h1 << 5));
    chk_reg("R6 enabled only", 3'd0, 32'h0000_0043);
    wr(3'd2, 32'hFFFF_FFFF);
    chk_reg("R6 none pending", 3'd0, 32'h0);
    @(negedge clk);
    chk("R8 loop irq falls", irq, 1'b0);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_force;
    wr(3'd1, 32'hFFFF_FFFF);
    chk_reg("R4 enable readback mask", 3'd1, 32'h8000_3FFF);
    wr(3'd1, 32'h8000_0000);
    @(negedge clk);
    chk("R9 force irq", irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 force holds", irq, 1'b1);
    wr(3'd1, 32'h0);
    @(negedge clk);
    chk("R9 force released", irq, 1'b0);
  endtask

  task automatic t_collide;
    pulse_src(17'h1 << 14);
    src_evt = 17'h1 << 14;
    addr = 3'd0; wdata = 32'h1 << 22; wr_en = 1'b1;
    @(negedge clk);
    src_evt = '0; wr_en = 1'b0; wdata = '0;
    chk_reg("R10 source event wins", 3'd0, 32'h0040_0000);
    wr(3'd0, 32'h0040_0000);
    chk_reg("R10 later clear works", 3'd0, 32'h0);
    loop_evt = 64'h1 << 10;
    addr = 3'd0; wdata = 32'h0000_0040 | 32'd10; wr_en = 1'b1;
    @(negedge clk);
    loop_evt = '0; wr_en = 1'b0; wdata = '0;
    chk_reg("R10 loop event wins", 3'd2, 32'h0000_0400);
    wr(3'd2, 32'h0000_0400);
    chk_reg("R10 loop clear works", 3'd2, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_evt = '0; loop_evt = '0; addr = '0; wdata = '0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_src_hold;
    t_w1c;
    t_shared;
    t_loop;
    t_sel_clear;
    t_force;
    t_collide;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule